// File: doc/BRIEF.md
# Light-Sensor Register Bank with Window Interrupt

This block is the byte-wide control and status register file of a light-sensing front end. An upstream serial target drives its register bus. The bus carries a 3-bit address, a write strobe, a read strobe and a strobe that marks the end of a read transfer. Two command bytes set the operating mode, the persistence count, the resolution and the range. Two byte pairs hold the low and high thresholds of a detection window. One further byte pair holds the latest 16-bit conversion result.

Conversion results arrive on a sample port with a valid strobe. The block keeps them only while a continuous conversion mode is selected. Each accepted sample is compared against the window. When enough consecutive samples lie outside the window, an interrupt flag sets and an active-low interrupt pin is driven. Both stay asserted until the host finishes reading command byte 0. The mode field is also decoded into three mode outputs for the converter.

Top module: `lux_reg_bank`

## Requirements
- R1: After reset, every register reads 00h except addresses 6 and 7 (high threshold), which read FFh, and irq_n is high.
- R2: Address 0 holds the mode field in bits 7:5, the interrupt flag in bit 2 and the persistence code in bits 1:0. Bits 4:3 read as zero. Host writes to bits 4:2 are discarded.
- R3: Address 1 holds the resolution code in bits 3:2 and the range code in bits 1:0, driven out on res_sel and range_sel. Bits 7:4 read as zero.
- R4: The mode outputs decode as follows: code 000 raises mode_off, 101 raises mode_visible and 110 raises mode_infrared. Every other code raises none of them.
- R5: A sample is accepted only in mode 101 or 110. It is then stored with its low byte at address 2 and its high byte at address 3. In any other mode, samples leave the data bytes and the interrupt unchanged.
- R6: A sample is out of window when it is strictly below the low threshold (addresses 4 low byte, 5 high byte) or strictly above the high threshold (addresses 6 low byte, 7 high byte). A sample equal to either threshold is in window.
- R7: Persistence codes 0, 1, 2 and 3 require 1, 4, 8 and 16 consecutive accepted out-of-window samples before the flag sets. An accepted in-window sample restarts the count.
- R8: While the flag is set, irq_n is low. The flag and the pin both clear at the clock edge that ends a read transfer of address 0.
- R9: A read of address 0 returns the flag as it was before that read's clear. Ending a read of any other address clears nothing.
- R10: If an out-of-window sample that completes the persistence count arrives in the same cycle as the clear, the flag stays set.
- R11: Addresses 2 and 3 are read-only to the host. The four threshold bytes read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid while it is high |
| bus_rd_end | input | 1 | End of a read transfer of the addressed byte |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| smp_data | input | 16 | Conversion result |
| smp_valid | input | 1 | Conversion result strobe |
| mode_off | output | 1 | Power-down mode selected |
| mode_visible | output | 1 | Continuous visible-light conversion selected |
| mode_infrared | output | 1 | Continuous infrared conversion selected |
| res_sel | output | 2 | Resolution code |
| range_sel | output | 2 | Range code |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench places samples exactly on each threshold and one count beyond it. A design with an inclusive compare would raise the interrupt on the equal values. It runs persistence chains that stop one sample short of the count, and chains broken by an in-window sample. A design that counted non-consecutive samples, or miscounted by one, would raise the pin early. It also reads address 0 in the same cycle as a tripping sample, and it ends reads of other addresses while the flag is set. A design that let the clear win, returned the post-clear flag or cleared on any read would show a wrong flag bit or a high pin.

// File: rtl/lux_pkg.sv
package lux_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int SMP_W   = 2 * REG_W;
  localparam int MODE_W  = 3;
  localparam int PCODE_W = 2;
  localparam int CNT_W   = 5;

  localparam logic [MODE_W-1:0] MODE_OFF = 3'b000;
  localparam logic [MODE_W-1:0] MODE_VIS = 3'b101;
  localparam logic [MODE_W-1:0] MODE_IR  = 3'b110;

  // Consecutive out-of-window samples needed for a persistence code
  function automatic logic [CNT_W-1:0] persist_need(input logic [PCODE_W-1:0] code);
    case (code)
      2'd0:    persist_need = 5'd1;
      2'd1:    persist_need = 5'd4;
      2'd2:    persist_need = 5'd8;
      default: persist_need = 5'd16;
    endcase
  endfunction

  // Strict comparison: equality with either bound counts as inside
  function automatic logic beyond_window(input logic [SMP_W-1:0] s,
                                         input logic [SMP_W-1:0] lo,
                                         input logic [SMP_W-1:0] hi);
    beyond_window = (s < lo) || (s > hi);
  endfunction
endpackage

// File: rtl/lux_cfg_regs.sv
module lux_cfg_regs
  import lux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [MODE_W-1:0] mode,
  output logic [PCODE_W-1:0] persist,
  output logic [1:0]        res,
  output logic [1:0]        rng,
  output logic [SMP_W-1:0]  thr_lo,
  output logic [SMP_W-1:0]  thr_hi
);
  localparam int NTHR = 4;
  localparam int THR_BASE = 4;

  logic [REG_W-1:0] thr_byte [NTHR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_OFF;
      persist <= '0;
      res     <= '0;
      rng     <= '0;
    end else if (wr) begin
      if (addr == 3'd0) begin
        mode    <= wdata[7:5];
        persist <= wdata[1:0];
      end
      if (addr == 3'd1) begin
        res <= wdata[3:2];
        rng <= wdata[1:0];
      end
    end
  end

  for (genvar k = 0; k < NTHR; k++) begin : g_thr
    localparam logic [REG_W-1:0] RST_VAL = (k >= 2) ? {REG_W{1'b1}} : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        thr_byte[k] <= RST_VAL;
      else if (wr && addr == ADDR_W'(THR_BASE + k))
        thr_byte[k] <= wdata;
    end
  end

  assign thr_lo = {thr_byte[1], thr_byte[0]};
  assign thr_hi = {thr_byte[3], thr_byte[2]};
endmodule

// File: rtl/lux_sample_hold.sv
module lux_sample_hold
  import lux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             active,
  input  logic [SMP_W-1:0] sample,
  output logic             accept,
  output logic [SMP_W-1:0] data_q
);
  assign accept = valid && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= sample;
  end
endmodule

// File: rtl/lux_window_irq.sv
module lux_window_irq
  import lux_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [SMP_W-1:0]   sample,
  input  logic [SMP_W-1:0]   thr_lo,
  input  logic [SMP_W-1:0]   thr_hi,
  input  logic [PCODE_W-1:0] persist,
  input  logic               clr,
  output logic               trip,
  output logic               flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = 5'd16;

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] run_inc;
  logic             outside;

  assign outside = beyond_window(sample, thr_lo, thr_hi);
  assign run_inc = (run_cnt >= CNT_MAX) ? CNT_MAX : run_cnt + 5'd1;
  assign trip    = accept && outside && (run_inc >= persist_need(persist));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (accept) run_cnt <= outside ? run_inc : '0;
  end

  // A tripping sample outranks the read-side clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (trip) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/lux_reg_bank.sv
module lux_reg_bank
  import lux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_rd_end,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              smp_valid,
  output logic              mode_off,
  output logic              mode_visible,
  output logic              mode_infrared,
  output logic [1:0]        res_sel,
  output logic [1:0]        range_sel,
  output logic              irq_n
);
  logic [MODE_W-1:0]  mode;
  logic [PCODE_W-1:0] persist;
  logic [SMP_W-1:0]   thr_lo, thr_hi, data_q;
  logic               accept, trip_evt, clr_evt, flag;

  lux_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mode(mode), .persist(persist), .res(res_sel), .rng(range_sel),
    .thr_lo(thr_lo), .thr_hi(thr_hi)
  );

  assign mode_off      = (mode == MODE_OFF);
  assign mode_visible  = (mode == MODE_VIS);
  assign mode_infrared = (mode == MODE_IR);

  lux_sample_hold u_hold (
    .clk(clk), .rst_n(rst_n), .valid(smp_valid),
    .active(mode_visible || mode_infrared), .sample(smp_data),
    .accept(accept), .data_q(data_q)
  );

  assign clr_evt = bus_rd_end && (bus_addr == 3'd0);

  lux_window_irq u_win (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sample(smp_data),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .persist(persist), .clr(clr_evt),
    .trip(trip_evt), .flag(flag)
  );

  assign irq_n = ~flag;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        3'd0: bus_rdata = {mode, 2'b00, flag, persist};
        3'd1: bus_rdata = {4'b0000, res_sel, range_sel};
        3'd2: bus_rdata = data_q[7:0];
        3'd3: bus_rdata = data_q[15:8];
        3'd4: bus_rdata = thr_lo[7:0];
        3'd5: bus_rdata = thr_lo[15:8];
        3'd6: bus_rdata = thr_hi[7:0];
        default: bus_rdata = thr_hi[15:8];
      endcase
    end
  end
endmodule

// File: rtl/lux_reg_bank_chk.sv
module lux_reg_bank_chk
  import lux_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             trip,
  input logic             clr,
  input logic             irq_n,
  input logic             smp_valid,
  input logic             mode_vis,
  input logic             mode_ir,
  input logic [SMP_W-1:0] data_q
);
  // R8: a trip drives the pin low on the next cycle
  p_trip_sets_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> !irq_n);

  // R8: a clear with no trip releases the pin
  p_clear_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !trip |=> irq_n);

  // R10: trip and clear together leave the pin asserted
  p_trip_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trip && clr |=> !irq_n);

  // R8: without trip or clear the pin holds
  p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trip && !clr |=> $stable(irq_n));

  // R5: samples outside the conversion modes leave the data unchanged
  p_ignore_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !mode_vis && !mode_ir |=> $stable(data_q));
endmodule

bind lux_reg_bank lux_reg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trip(trip_evt), .clr(clr_evt), .irq_n(irq_n),
  .smp_valid(smp_valid), .mode_vis(mode_visible), .mode_ir(mode_infrared),
  .data_q(data_q)
);

// File: tb/test_lux_reg_bank.sv
module test_lux_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_rd_end = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] smp_data = '0;
  logic        smp_valid = 1'b0;
  logic        mode_off, mode_visible, mode_infrared, irq_n;
  logic [1:0]  res_sel, range_sel;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  lux_reg_bank i_lux_reg_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rd_end(bus_rd_end),
    .bus_rdata(bus_rdata), .smp_data(smp_data), .smp_valid(smp_valid),
    .mode_off(mode_off), .mode_visible(mode_visible),
    .mode_infrared(mode_infrared), .res_sel(res_sel), .range_sel(range_sel),
    .irq_n(irq_n)
  );

  // Monitor: compares every read against the scoreboard head
  always @(negedge clk) begin
    if (bus_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: read with empty scoreboard, got %02h", "SB", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata=%02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  // Driver: pushes the expected byte, then issues a single-cycle read transfer
  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1; bus_rd_end = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_rd_end = 1'b0;
  endtask

  task automatic smp(input logic [15:0] v);
    @(posedge clk); #1;
    smp_data = v; smp_valid = 1'b1;
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic rd0_with_smp(input logic [15:0] v, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_addr = 3'd0; bus_rd = 1'b1; bus_rd_end = 1'b1;
    smp_data = v; smp_valid = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_rd_end = 1'b0; smp_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: timeout, got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    for (int a = 0; a < 8; a++) rd(3'(a), (a >= 6) ? 8'hFF : 8'h00, "R1 reset value");

    // R2 and R4: reserved mode, read-only flag and zero bits
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'hE3, "R2 command0 layout");
    chk("R4 reserved 111", {5'd0, mode_off, mode_visible, mode_infrared}, 8'h00);
    // R3
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R3 command1 layout");
    chk("R3 res/range pins", {4'd0, res_sel, range_sel}, 8'h0F);
    wr(3'd1, 8'h06);
    chk("R3 res/range pins 2", {4'd0, res_sel, range_sel}, 8'h06);

    // R4 decode
    wr(3'd0, 8'h00);
    chk("R4 mode 000", {5'd0, mode_off, mode_visible, mode_infrared}, 8'h04);
    wr(3'd0, 8'hC0);
    chk("R4 mode 110", {5'd0, mode_off, mode_visible, mode_infrared}, 8'h01);
    wr(3'd0, 8'hA0);
    chk("R4 mode 101", {5'd0, mode_off, mode_visible, mode_infrared}, 8'h02);

    // R5 samples ignored in power-down
    wr(3'd0, 8'h00);
    smp(16'h1234);
    rd(3'd2, 8'h00, "R5 ignored in off mode lsb");
    wr(3'd0, 8'hA0);
    smp(16'h1234);
    rd(3'd2, 8'h34, "R5 data lsb");
    rd(3'd3, 8'h12, "R5 data msb");

    // R11 data read-only, thresholds read/write
    wr(3'd2, 8'h55);
    wr(3'd3, 8'h66);
    rd(3'd2, 8'h34, "R11 data lsb read-only");
    rd(3'd3, 8'h12, "R11 data msb read-only");
    wr(3'd4, 8'h00); wr(3'd5, 8'h10);
    wr(3'd6, 8'h00); wr(3'd7, 8'h20);
    rd(3'd5, 8'h10, "R11 low threshold msb");
    rd(3'd7, 8'h20, "R11 high threshold msb");

    // R6 window edges (low 1000h, high 2000h, persistence code 0)
    smp(16'h1000);
    chk("R6 equal low", {7'd0, irq_n}, 8'h01);
    smp(16'h2000);
    chk("R6 equal high", {7'd0, irq_n}, 8'h01);
    smp(16'h2001);
    chk("R6 above high", {7'd0, irq_n}, 8'h00);
    rd(3'd0, 8'hA4, "R9 flag before clear");
    chk("R8 cleared", {7'd0, irq_n}, 8'h01);
    rd(3'd0, 8'hA0, "R8 flag cleared");
    smp(16'h0FFF);
    chk("R6 below low", {7'd0, irq_n}, 8'h00);
    // R9 ending a read of another address clears nothing
    rd(3'd2, 8'hFF, "R9 other read data");
    chk("R9 other read keeps irq", {7'd0, irq_n}, 8'h00);
    rd(3'd0, 8'hA4, "R9 flag read");
    chk("R8 cleared again", {7'd0, irq_n}, 8'h01);

    // R5 reserved mode ignores out-of-window samples
    wr(3'd0, 8'h20);
    smp(16'h0001);
    chk("R5 reserved ignores", {7'd0, irq_n}, 8'h01);
    rd(3'd2, 8'hFF, "R5 data held in reserved mode");

    // R7 persistence code 1 -> 4 samples, restarted by in-window
    wr(3'd0, 8'hC1);
    smp(16'h1800);
    for (int i = 0; i < 3; i++) smp(16'h0005);
    chk("R7 three of four", {7'd0, irq_n}, 8'h01);
    smp(16'h1800);
    for (int i = 0; i < 3; i++) smp(16'h3000);
    chk("R7 count restarted", {7'd0, irq_n}, 8'h01);
    smp(16'h3000);
    chk("R7 fourth trips", {7'd0, irq_n}, 8'h00);
    rd(3'd0, 8'hC5, "R7 flag set code1");

    // R7 persistence code 3 -> 16 samples
    wr(3'd0, 8'hC3);
    smp(16'h1800);
    for (int i = 0; i < 15; i++) smp(16'h0000);
    chk("R7 fifteen of sixteen", {7'd0, irq_n}, 8'h01);
    smp(16'h0000);
    chk("R7 sixteenth trips", {7'd0, irq_n}, 8'h00);
    rd(3'd0, 8'hC7, "R7 flag set code3");

    // R7 persistence code 2 -> 8 samples
    wr(3'd0, 8'hA2);
    smp(16'h1800);
    for (int i = 0; i < 7; i++) smp(16'hFFFF);
    chk("R7 seven of eight", {7'd0, irq_n}, 8'h01);
    smp(16'hFFFF);
    chk("R7 eighth trips", {7'd0, irq_n}, 8'h00);
    rd(3'd0, 8'hA6, "R7 flag set code2");

    // R10 tripping sample in the clear cycle keeps the flag
    wr(3'd0, 8'hA0);
    smp(16'h0100);
    chk("R10 setup trip", {7'd0, irq_n}, 8'h00);
    rd0_with_smp(16'h0100, 8'hA4, "R10 read during trip");
    chk("R10 flag kept", {7'd0, irq_n}, 8'h00);
    rd(3'd0, 8'hA4, "R10 flag still set");
    chk("R10 later clear", {7'd0, irq_n}, 8'h01);

    repeat (2) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL SB: %0d reads pending, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule